// File: doc/BRIEF.md
# Buffer-Full Interrupt Handshake Controller

This controller watches the status of a capture buffer of 4096 words, each 32 bits wide, that a processing pipeline fills. When the buffer becomes full it sends the host a single-cycle interrupt request. Each full buffer is drained by one 16 KB transfer. After sending the request, the controller raises no further request until the host acknowledges that the drain transfer has ended. The host acknowledges whether the transfer succeeded or failed. This keeps the host and the buffer in lockstep: there is exactly one request per acknowledged drain.

The controller has three states. IDLE_WAIT_FULL waits for the full condition. IRQ_PULSE lasts exactly one cycle and drives the request. WAIT_ACK holds until the acknowledge arrives. The transitions are:
- full_seen: IDLE_WAIT_FULL to IRQ_PULSE.
- pulse_done: IRQ_PULSE to WAIT_ACK, always taken.
- ack_rearm: WAIT_ACK to IDLE_WAIT_FULL, when the acknowledge arrives and the buffer is not full.
- ack_refire: WAIT_ACK to IRQ_PULSE, when the acknowledge arrives while the buffer is already full, so that a full condition is not lost.

An acknowledge outside WAIT_ACK is a protocol error. It sets a sticky flag, which software clears.

Top module: `fullbuf_irq_ctrl`

## Requirements
- R1: While the synchronous reset `rst` is high at a clock edge, the state after that edge is IDLE_WAIT_FULL, `irq` is low and `proto_err` is low.
- R2: The full condition is true when `fifo_empty` is low and either `fifo_full` is high or `fifo_count` equals the buffer depth (4096). With `fifo_empty` high, the full condition is never true.
- R3: From IDLE_WAIT_FULL, a full condition at a clock edge moves the block to IRQ_PULSE. `irq` is high for exactly the one cycle spent in IRQ_PULSE.
- R4: IRQ_PULSE always moves to WAIT_ACK on the next edge. WAIT_ACK holds, and `irq` stays low, until `host_ack` is sampled high, however long the full condition persists.
- R5: In WAIT_ACK, `host_ack` with no full condition moves the block to IDLE_WAIT_FULL without a request.
- R6: In WAIT_ACK, `host_ack` together with a full condition moves the block directly to IRQ_PULSE, so `irq` is high in the next cycle.
- R7: `host_ack` sampled in IDLE_WAIT_FULL or IRQ_PULSE does not change the state sequence and sets `proto_err` at that edge.
- R8: `proto_err` stays high until `err_clear` is sampled with no stray acknowledge in the same cycle. When both occur in the same cycle, setting wins.
- R9: `state_o` reports the state as 0 for IDLE_WAIT_FULL, 1 for IRQ_PULSE and 2 for WAIT_ACK. The value 3 never appears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| fifo_full | input | 1 | Buffer full flag |
| fifo_empty | input | 1 | Buffer empty flag |
| fifo_count | input | 13 | Buffer fill level in words |
| host_ack | input | 1 | Host acknowledge of drain completion |
| err_clear | input | 1 | Clears the sticky protocol-error flag |
| irq | output | 1 | One-cycle interrupt request |
| state_o | output | 2 | Current state code |
| proto_err | output | 1 | Sticky flag for an acknowledge outside WAIT_ACK |

## Verification
The assertions assume that the buffer status inputs and `host_ack` are synchronous to `clk` and are never X after reset. They also assume that `host_ack` is a level sampled once per edge, not a pulse that must be caught asynchronously. The stimulus changes every input only at falling edges and holds it for whole cycles. It presents full status both through the flag and through the count, and in the empty-inconsistent combination. It also sends acknowledges deliberately in each state, so the legal and the stray cases both occur.

// File: rtl/fbi_pkg.sv
package fbi_pkg;
    typedef enum logic [1:0] {
        ST_IDLE_WAIT_FULL = 2'd0,
        ST_IRQ_PULSE      = 2'd1,
        ST_WAIT_ACK       = 2'd2
    } fbi_state_e;
endpackage

// File: rtl/fbi_full_detect.sv
module fbi_full_detect #(
    parameter int DEPTH = 4096,
    parameter int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             fifo_full,
    input  logic             fifo_empty,
    input  logic [CNT_W-1:0] fifo_count,
    output logic             full_cond
);
    localparam logic [CNT_W-1:0] LEVEL_FULL = CNT_W'(DEPTH);

    // Either the flag or the count may announce fullness; an empty flag vetoes both.
    always_comb begin
        full_cond = !fifo_empty && (fifo_full || (fifo_count == LEVEL_FULL));
    end
endmodule

// File: rtl/fbi_fsm.sv
module fbi_fsm
    import fbi_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       full_cond,
    input  logic       host_ack,
    output fbi_state_e state_q,
    output logic       irq,
    output logic       stray_ack
);
    fbi_state_e state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE_WAIT_FULL: if (full_cond) state_d = ST_IRQ_PULSE;       // full_seen
            ST_IRQ_PULSE:      state_d = ST_WAIT_ACK;                       // pulse_done
            ST_WAIT_ACK: begin
                if (host_ack) begin
                    state_d = full_cond ? ST_IRQ_PULSE                      // ack_refire
                                        : ST_IDLE_WAIT_FULL;                // ack_rearm
                end
            end
            default:           state_d = ST_IDLE_WAIT_FULL;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_IDLE_WAIT_FULL;
        else     state_q <= state_d;
    end

    always_comb begin
        irq       = (state_q == ST_IRQ_PULSE);
        stray_ack = host_ack && (state_q != ST_WAIT_ACK);
    end
endmodule

// File: rtl/fbi_err_flag.sv
module fbi_err_flag (
    input  logic clk,
    input  logic rst,
    input  logic set_i,
    input  logic clear_i,
    output logic flag_q
);
    always_ff @(posedge clk) begin
        if (rst)          flag_q <= 1'b0;
        else if (set_i)   flag_q <= 1'b1;
        else if (clear_i) flag_q <= 1'b0;
    end
endmodule

// File: rtl/fullbuf_irq_ctrl.sv
module fullbuf_irq_ctrl
    import fbi_pkg::*;
#(
    parameter int DEPTH = 4096,
    parameter int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             fifo_full,
    input  logic             fifo_empty,
    input  logic [CNT_W-1:0] fifo_count,
    input  logic             host_ack,
    input  logic             err_clear,
    output logic             irq,
    output logic [1:0]       state_o,
    output logic             proto_err
);
    logic       full_cond;
    logic       stray_ack;
    fbi_state_e state_q;

    fbi_full_detect #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_detect (
        .fifo_full  (fifo_full),
        .fifo_empty (fifo_empty),
        .fifo_count (fifo_count),
        .full_cond  (full_cond)
    );

    fbi_fsm u_fsm (
        .clk       (clk),
        .rst       (rst),
        .full_cond (full_cond),
        .host_ack  (host_ack),
        .state_q   (state_q),
        .irq       (irq),
        .stray_ack (stray_ack)
    );

    fbi_err_flag u_err (
        .clk     (clk),
        .rst     (rst),
        .set_i   (stray_ack),
        .clear_i (err_clear),
        .flag_q  (proto_err)
    );

    assign state_o = state_q;
endmodule

// File: rtl/fbi_checker.sv
module fbi_checker #(
    parameter int DEPTH = 4096,
    parameter int CNT_W = $clog2(DEPTH + 1)
) (
    input logic             clk,
    input logic             rst,
    input logic             fifo_full,
    input logic             fifo_empty,
    input logic [CNT_W-1:0] fifo_count,
    input logic             host_ack,
    input logic             err_clear,
    input logic             irq,
    input logic [1:0]       state_o,
    input logic             proto_err
);
    logic full_seen;
    assign full_seen = !fifo_empty && (fifo_full || fifo_count == CNT_W'(DEPTH));

    p_reset_idle_r1: assert property (@(posedge clk)
        rst |=> (state_o == 2'd0 && !irq && !proto_err));

    p_irq_one_cycle_r3: assert property (@(posedge clk) disable iff (rst)
        irq |=> !irq);

    p_idle_full_fires_r3: assert property (@(posedge clk) disable iff (rst)
        (state_o == 2'd0 && full_seen) |=> irq);

    p_pulse_to_wait_r4: assert property (@(posedge clk) disable iff (rst)
        (state_o == 2'd1) |=> (state_o == 2'd2));

    p_hold_wait_r4: assert property (@(posedge clk) disable iff (rst)
        (state_o == 2'd2 && !host_ack) |=> (state_o == 2'd2 && !irq));

    p_rearm_idle_r5: assert property (@(posedge clk) disable iff (rst)
        (state_o == 2'd2 && host_ack && !full_seen) |=> (state_o == 2'd0));

    p_refire_r6: assert property (@(posedge clk) disable iff (rst)
        (state_o == 2'd2 && host_ack && full_seen) |=> irq);

    p_stray_sets_err_r7: assert property (@(posedge clk) disable iff (rst)
        (host_ack && state_o != 2'd2) |=> proto_err);

    p_err_sticky_r8: assert property (@(posedge clk) disable iff (rst)
        (proto_err && !err_clear) |=> proto_err);

    p_state_code_r9: assert property (@(posedge clk) disable iff (rst)
        state_o != 2'd3);
endmodule

bind fullbuf_irq_ctrl fbi_checker #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .fifo_full  (fifo_full),
    .fifo_empty (fifo_empty),
    .fifo_count (fifo_count),
    .host_ack   (host_ack),
    .err_clear  (err_clear),
    .irq        (irq),
    .state_o    (state_o),
    .proto_err  (proto_err)
);

// File: tb/fullbuf_irq_ctrl_tb.sv
`timescale 1ns/1ps
module fullbuf_irq_ctrl_tb;
    localparam int DEPTH = 4096;
    localparam int CNT_W = $clog2(DEPTH + 1);

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             fifo_full = 1'b0;
    logic             fifo_empty = 1'b1;
    logic [CNT_W-1:0] fifo_count = '0;
    logic             host_ack = 1'b0;
    logic             err_clear = 1'b0;
    logic             irq;
    logic [1:0]       state_o;
    logic             proto_err;

    int n_run  = 0;
    int n_fail = 0;
    int cyc    = 0;
    int exp_q[$];
    bit done   = 1'b0;

    always #2 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    fullbuf_irq_ctrl #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_dut (
        .clk(clk), .rst(rst), .fifo_full(fifo_full), .fifo_empty(fifo_empty),
        .fifo_count(fifo_count), .host_ack(host_ack), .err_clear(err_clear),
        .irq(irq), .state_o(state_o), .proto_err(proto_err)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", tag, act, exp, cyc);
        end
    endtask

    // driver side: announce that a request must appear one edge from now
    task automatic expect_irq_next();
        exp_q.push_back(cyc + 1);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // monitor: every request pulse must match the head of the queue
    always @(negedge clk) begin
        if (!rst && irq) begin
            if (exp_q.size() == 0) begin
                chk(1'b0, "R3/R4 unexpected irq", cyc, -1);
            end else begin
                int e;
                e = exp_q.pop_front();
                chk(e == cyc, "R3 irq cycle", cyc, e);
            end
        end
    end

    initial begin
        #(200000 * 4);
        if (!done) begin
            chk(1'b0, "watchdog", 0, 1);
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        idle(3);
        chk(state_o == 2'd0, "R1 reset state", state_o, 0);
        chk(irq == 1'b0 && proto_err == 1'b0, "R1 reset outputs", {irq, proto_err}, 0);
        rst = 1'b0;
        fifo_empty = 1'b0;
        idle(2);

        // R3: full flag in idle -> one pulse; R4 held full gives no more
        fifo_full = 1'b1; expect_irq_next();
        @(negedge clk);
        chk(state_o == 2'd1, "R9 IRQ_PULSE code", state_o, 1);
        idle(6);
        chk(state_o == 2'd2, "R4 holds WAIT_ACK", state_o, 2);
        chk(exp_q.size() == 0, "R4 single request", exp_q.size(), 0);

        // R6: ack while still full -> immediate refire
        host_ack = 1'b1; expect_irq_next();
        @(negedge clk);
        host_ack = 1'b0; fifo_full = 1'b0;
        chk(state_o == 2'd1, "R6 refire state", state_o, 1);
        idle(2);
        chk(state_o == 2'd2, "R4 after refire", state_o, 2);

        // R5: ack without full -> idle, no request
        host_ack = 1'b1;
        @(negedge clk);
        host_ack = 1'b0;
        chk(state_o == 2'd0, "R5 rearm to idle", state_o, 0);
        chk(proto_err == 1'b0, "R5 legal ack no error", proto_err, 0);

        // R7: stray ack in idle
        host_ack = 1'b1;
        @(negedge clk);
        host_ack = 1'b0;
        chk(state_o == 2'd0, "R7 stray ack state", state_o, 0);
        chk(proto_err == 1'b1, "R7 stray ack flag", proto_err, 1);
        idle(4);
        chk(proto_err == 1'b1, "R8 sticky", proto_err, 1);
        err_clear = 1'b1;
        @(negedge clk);
        err_clear = 1'b0;
        chk(proto_err == 1'b0, "R8 clear", proto_err, 0);

        // R8: stray ack and clear together -> set wins
        host_ack = 1'b1; err_clear = 1'b1;
        @(negedge clk);
        host_ack = 1'b0; err_clear = 1'b0;
        chk(proto_err == 1'b1, "R8 set wins", proto_err, 1);
        err_clear = 1'b1;
        @(negedge clk);
        err_clear = 1'b0;

        // R2: empty vetoes a full flag
        fifo_full = 1'b1; fifo_empty = 1'b1;
        idle(3);
        chk(state_o == 2'd0, "R2 empty veto", state_o, 0);
        fifo_full = 1'b0; fifo_empty = 1'b0;

        // R2: count reaching depth counts as full
        fifo_count = CNT_W'(DEPTH - 1);
        idle(2);
        chk(state_o == 2'd0, "R2 depth-1 not full", state_o, 0);
        fifo_count = CNT_W'(DEPTH); expect_irq_next();
        @(negedge clk);
        fifo_count = '0;
        chk(state_o == 2'd1, "R2 count full", state_o, 1);
        @(negedge clk);
        host_ack = 1'b1;
        @(negedge clk);
        host_ack = 1'b0;
        chk(state_o == 2'd0, "R5 after count drain", state_o, 0);

        // R7: ack during IRQ_PULSE is stray and does not alter the sequence
        fifo_full = 1'b1; expect_irq_next();
        @(negedge clk);
        fifo_full = 1'b0; host_ack = 1'b1;
        @(negedge clk);
        host_ack = 1'b0;
        chk(state_o == 2'd2, "R7 pulse ack ignored", state_o, 2);
        chk(proto_err == 1'b1, "R7 pulse ack flag", proto_err, 1);

        // R1: reset in WAIT_ACK
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        chk(state_o == 2'd0 && proto_err == 1'b0, "R1 mid-run reset",
            {state_o, proto_err}, 0);
        idle(3);
        chk(exp_q.size() == 0, "R3 all expected requests seen", exp_q.size(), 0);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule